// File: doc/BRIEF.md
# Mod-3 Channel Hash MSB Solver

This block recovers the two most significant bits of a memory port address when the memory channels are interleaved three or six ways. In those layouts the hardware does not select a channel from a plain bit field. It hashes the address into a residue modulo 3, held as a 3-bit one-hot code, and picks the channel from that residue. To rebuild a full address, the missing top bits must be the value that makes the hash agree with the channel's group. The block takes the port address, the layout (three or six channels) and the group identifier. It returns that 2-bit value.

The solver does not compute a modulus. It builds two one-hot residues. The first comes from a chain of right rotations driven by address bits [20:15]. The second is a target made from the group identifier, rotated left by address bits [8:7]. The solver then turns the target left one place per clock until the two residues agree, and the number of turns is the answer. A request is accepted through a valid/ready handshake. The answer comes back as a one-cycle valid pulse with the count and an error flag.

Top module: `mod3_msb_solver`

## Requirements
- R1: After reset, `req_ready_o` is 1, `rsp_valid_o` is 0, `rsp_msb_o` is 0 and `rsp_err_o` is 0.
- R2: The address residue uses a one-hot code in which value v maps to 3'b100 shifted right by (v mod 3), so 0, 1, 2 and 3 give 100, 010, 001 and 100. The residue starts as the code of address bits [16:15]. It is rotated right by the value of bits [18:17], then rotated right again by the value of bits [20:19]. A right rotation moves bits [2:1] down one place and puts bit 0 into bit 2.
- R3: With `req_six_i`=0, the target is the one-hot code of `req_grp_id_i`, rotated left by the value of address bits [8:7]. A left rotation is the inverse of the right rotation.
- R4: With `req_six_i`=1, the group identifier is reduced to `req_grp_id_i & 3'b110` before encoding, and the left rotation uses only address bit 8, with bit 7 taken as 0.
- R5: `rsp_msb_o` is the number of single left rotations of the target needed to equal the address residue, always 0, 1 or 2.
- R6: A response is a single-cycle pulse of `rsp_valid_o`. It appears on the clock edge 1+`rsp_msb_o` cycles after the edge that accepted the request.
- R7: `req_ready_o` is 0 from the edge after an acceptance until the response is produced. A request presented while it is 0 is not taken and produces no response.
- R8: `req_ready_o` is 1 in the cycle `rsp_valid_o` is 1, so a new request can be accepted in the same cycle a response is delivered.
- R9: `rsp_err_o` is 1 only if three compares fail, which legal inputs cannot cause, and it then comes with `rsp_msb_o`=0. For every request reachable at the ports, `rsp_err_o` is 0.
- R10: Address bits outside [20:15] and [8:7] have no effect on the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Solver idle; a request is taken when both are 1 |
| req_addr_i | input | ADDR_W | Port address after group-ID insertion |
| req_six_i | input | 1 | 1: six-channel group, 0: three-channel group |
| req_grp_id_i | input | GID_W | Group identifier |
| rsp_valid_o | output | 1 | One-cycle response strobe |
| rsp_msb_o | output | 2 | Recovered top-bit value |
| rsp_err_o | output | 1 | No match found within three compares |

## Verification
Two events can land in the same cycle: a response is delivered, and the next request is accepted. This happens because ready rises in the cycle the result strobes. The bench provokes it by holding `req_valid_i` high almost all the time, so each new vector waits at the handshake and is taken in the response cycle. A cycle-by-cycle model predicts ready, strobe, count and error on every clock. It covers every combination of the relevant address bits, group identifier and layout, with random values in the irrelevant bits and random idle gaps.

// File: rtl/mod3_pkg.sv
package mod3_pkg;
  localparam int RES_W   = 3;
  localparam int MAX_ROT = 3;
  localparam int CNT_W   = $clog2(MAX_ROT + 1);
  // address bit positions consumed by the hash
  localparam int A_SEED  = 15;
  localparam int A_ROT1  = 17;
  localparam int A_ROT2  = 19;
  localparam int A_GSEL  = 7;

  typedef logic [RES_W-1:0] res_t;
  typedef enum logic { S_IDLE, S_SRCH } srch_state_e;

  function automatic res_t enc_res(input logic [7:0] v);
    return res_t'(3'b100 >> (v % 3));
  endfunction

  function automatic res_t rot_r1(input res_t x);
    return {x[0], x[2:1]};
  endfunction

  function automatic res_t rot_l1(input res_t x);
    return {x[1:0], x[2]};
  endfunction

  function automatic res_t rot_r(input res_t x, input logic [1:0] n);
    res_t y = x;
    for (int i = 0; i < 3; i++) if (i < int'(n)) y = rot_r1(y);
    return y;
  endfunction

  function automatic res_t rot_l(input res_t x, input logic [1:0] n);
    res_t y = x;
    for (int i = 0; i < 3; i++) if (i < int'(n)) y = rot_l1(y);
    return y;
  endfunction
endpackage

// File: rtl/mod3_hash_front.sv
module mod3_hash_front
  import mod3_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int GID_W  = 3
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              six_i,
  input  logic [GID_W-1:0]  gid_i,
  output res_t              addr_res_o,
  output res_t              tgt_res_o
);
  res_t             seed, stage1;
  logic [GID_W-1:0] gid_eff;
  logic [1:0]       gsel;

  assign seed       = enc_res(8'(addr_i[A_SEED +: 2]));
  assign stage1     = rot_r(seed, addr_i[A_ROT1 +: 2]);
  assign addr_res_o = rot_r(stage1, addr_i[A_ROT2 +: 2]);

  // six-way: group LSB already lives in the low select bit
  assign gid_eff   = six_i ? (gid_i & ~GID_W'(1)) : gid_i;
  assign gsel      = six_i ? {addr_i[A_GSEL+1], 1'b0} : addr_i[A_GSEL +: 2];
  assign tgt_res_o = rot_l(enc_res(8'(gid_eff)), gsel);
endmodule

// File: rtl/mod3_rot_search.sv
module mod3_rot_search
  import mod3_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_valid_i,
  output logic       req_ready_o,
  input  res_t       addr_res_i,
  input  res_t       tgt_res_i,
  output logic       rsp_valid_o,
  output logic [1:0] rsp_msb_o,
  output logic       rsp_err_o
);
  srch_state_e      state_q;
  res_t             ref_q, tgt_q;
  logic [CNT_W-1:0] cnt_q;
  logic             vld_q, err_q;
  logic [1:0]       msb_q;

  assign req_ready_o = (state_q == S_IDLE);
  assign rsp_valid_o = vld_q;
  assign rsp_msb_o   = msb_q;
  assign rsp_err_o   = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      ref_q   <= '0;
      tgt_q   <= '0;
      cnt_q   <= '0;
      vld_q   <= 1'b0;
      err_q   <= 1'b0;
      msb_q   <= '0;
    end else begin
      vld_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (req_valid_i) begin
          ref_q   <= addr_res_i;
          tgt_q   <= tgt_res_i;
          cnt_q   <= '0;
          state_q <= S_SRCH;
        end
        S_SRCH: begin
          if (tgt_q == ref_q) begin
            vld_q   <= 1'b1;
            msb_q   <= 2'(cnt_q);
            err_q   <= 1'b0;
            state_q <= S_IDLE;
          end else if (cnt_q == CNT_W'(MAX_ROT - 1)) begin
            vld_q   <= 1'b1;
            msb_q   <= '0;
            err_q   <= 1'b1;
            state_q <= S_IDLE;
          end else begin
            tgt_q <= rot_l1(tgt_q);
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  a_r2_res_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_SRCH) |-> ($onehot(ref_q) && $onehot(tgt_q)));
  a_r5_msb_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (rsp_msb_o != 2'd3));
  a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
  a_r7_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);
  a_r8_ready_on_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> req_ready_o);
  a_r9_err_msb_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_err_o) |-> (rsp_msb_o == 2'd0));
endmodule

// File: rtl/mod3_msb_solver.sv
module mod3_msb_solver
  import mod3_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int GID_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_six_i,
  input  logic [GID_W-1:0]  req_grp_id_i,
  output logic              rsp_valid_o,
  output logic [1:0]        rsp_msb_o,
  output logic              rsp_err_o
);
  res_t addr_res, tgt_res;

  mod3_hash_front #(.ADDR_W(ADDR_W), .GID_W(GID_W)) u_front (
    .addr_i     (req_addr_i),
    .six_i      (req_six_i),
    .gid_i      (req_grp_id_i),
    .addr_res_o (addr_res),
    .tgt_res_o  (tgt_res)
  );

  mod3_rot_search u_search (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .addr_res_i  (addr_res),
    .tgt_res_i   (tgt_res),
    .rsp_valid_o (rsp_valid_o),
    .rsp_msb_o   (rsp_msb_o),
    .rsp_err_o   (rsp_err_o)
  );
endmodule

// File: tb/mod3_msb_solver_bench.sv
module mod3_msb_solver_bench;
  localparam int ADDR_W = 40;
  localparam int GID_W  = 3;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_valid_i = 1'b0;
  logic              req_ready_o;
  logic [ADDR_W-1:0] req_addr_i = '0;
  logic              req_six_i = 1'b0;
  logic [GID_W-1:0]  req_grp_id_i = '0;
  logic              rsp_valid_o;
  logic [1:0]        rsp_msb_o;
  logic              rsp_err_o;

  int n_chk = 0, n_bad = 0;

  always #5 clk_i = ~clk_i;

  mod3_msb_solver #(.ADDR_W(ADDR_W), .GID_W(GID_W)) u_mod3_msb_solver (.*);

  // residue arithmetic: right rotate adds 1, left rotate subtracts 1
  function automatic int ref_msb(input logic [ADDR_W-1:0] a, input bit six,
                                 input int gid);
    int ar, t, s;
    ar = (int'(a[16:15]) % 3 + int'(a[18:17]) + int'(a[20:19])) % 3;
    s  = int'(a[8:7]);
    if (six) begin gid = gid & 6; s = s & 2; end
    t = ((gid % 3) - s + 6) % 3;
    return (t - ar + 3) % 3;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // model state
  int rem = 0;
  bit exp_vld = 0;
  int exp_msb = 0;
  bit exp_six = 0;
  bit done = 0;

  initial begin
    #200000000;
    n_bad++;
    $display("FAIL watchdog R6 actual=%0d expected=%0d", 0, 1);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int pend_msb;
    bit pend_six;
    repeat (3) @(negedge clk_i);
    // R1: reset state
    chk(req_ready_o == 1'b1, "R1 ready", req_ready_o, 1);
    chk(rsp_valid_o == 1'b0, "R1 valid", rsp_valid_o, 0);
    chk(rsp_msb_o == 2'd0,   "R1 msb",   rsp_msb_o, 0);
    chk(rsp_err_o == 1'b0,   "R1 err",   rsp_err_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // exhaustive sweep over relevant fields; R10: other bits random
    for (int six = 0; six < 2; six++)
      for (int g = 0; g < 8; g++)
        for (int hi = 0; hi < 64; hi++)
          for (int lo = 0; lo < 4; lo++) begin
            logic [ADDR_W-1:0] a;
            bit taken;
            a = {$urandom, $urandom};
            a[20:15] = 6'(hi);
            a[8:7]   = 2'(lo);
            taken = 0;
            while (!taken) begin
              bit drv;
              drv = ($urandom % 8) != 0;
              req_valid_i  = drv;
              req_addr_i   = a;
              req_six_i    = six[0];
              req_grp_id_i = 3'(g);
              // R7: scramble ignored request fields while busy
              if (rem != 0) req_addr_i = {$urandom, $urandom};
              @(posedge clk_i);
              taken = drv && (rem == 0);
              pend_msb = ref_msb(a, six[0], g);
              pend_six = six[0];
              exp_vld = (rem == 1);
              if (rem > 0) rem--;
              if (taken) rem = pend_msb + 1;
              @(negedge clk_i);
              // R7/R8: ready tracks the model
              chk(req_ready_o == (rem == 0), "R7 R8 ready", req_ready_o, int'(rem == 0));
              chk(rsp_valid_o == exp_vld, "R6 R7 valid", rsp_valid_o, int'(exp_vld));
              if (exp_vld && rsp_valid_o) begin
                chk(rsp_msb_o == 2'(exp_msb), exp_six ? "R4 R5 msb" : "R2 R3 R5 msb",
                    rsp_msb_o, exp_msb);
                chk(rsp_err_o == 1'b0, "R9 err", rsp_err_o, 0);
              end
              if (taken) begin exp_msb_next(pend_msb, pend_six); end
            end
          end
    req_valid_i = 1'b0;
    // drain the last response
    repeat (4) begin
      @(posedge clk_i);
      exp_vld = (rem == 1);
      if (rem > 0) rem--;
      @(negedge clk_i);
      chk(rsp_valid_o == exp_vld, "R6 drain valid", rsp_valid_o, int'(exp_vld));
      if (exp_vld && rsp_valid_o)
        chk(rsp_msb_o == 2'(exp_msb), "R5 drain msb", rsp_msb_o, exp_msb);
    end
    chk(req_ready_o == 1'b1, "R8 idle ready", req_ready_o, 1);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  // single outstanding request: latch its expected result
  task automatic exp_msb_next(input int m, input bit s);
    exp_msb = m;
    exp_six = s;
  endtask
endmodule